// File: doc/BRIEF.md
# Delay-Slot Branch Sequencer

This block holds the program counter of a small command-processing microcontroller and handles its control transfers. Each cycle in which `instr_valid` is high, the instruction at `pc` executes. A decoder outside the block provides the control fields: the opcode class, a condition mode, a 5-bit immediate or bit index, the source register value, and a 16-bit relative offset. The instruction memory, the ALU and the register file are outside this block.

All control transfers have exactly one architectural delay slot. The instruction that follows a branch, jump, call or return always executes. After that slot, the PC moves to the resolved target. Conditional branches test one of two things: equality of the source value with a zero-extended 5-bit immediate, or the state of one selected bit of the source value. Relative targets are signed and count from the address of the branch itself. A four-entry return-address stack supports nested calls.

The stack can overflow or underflow. A control instruction can also appear in a delay slot, which is not supported. Each of these raises a sticky error flag. The controller state machine has two states. `S_RUN` is normal sequential issue. `S_SLOT` means the delay slot is executing and the resolved target is pending. The transition *issue-control* goes from `S_RUN` to `S_SLOT` when a valid control instruction executes. The transition *retire-slot* goes from `S_SLOT` to `S_RUN` when the slot instruction executes. When `instr_valid` is low, both states hold.

Top module: `pc_branch_seq`

## Requirements
- R1: After reset, `pc` equals 0 and `seq_err` is 0.
- R2: In `S_RUN`, a valid non-control instruction advances `pc` by 1. Opcodes 0, 6 and 7 are non-control. When `instr_valid` is low, `pc` and the state hold.
- R3: A valid control instruction at address P moves `pc` to P+1 (the delay slot). This happens for opcodes 1 through 5, whether the transfer is taken or not.
- R4: After the delay slot executes, a taken transfer sets `pc` to P + sign-extended `rel_offset`, modulo 2^16.
- R5: After the delay slot executes, a conditional branch that is not taken sets `pc` to P+2.
- R6: When `bit_mode`=0, opcode 1 (branch-if-equal) is taken when `src_val` equals the zero-extended `cond_imm`. Opcode 2 (branch-if-not-equal) is taken when they differ. A zero source with immediate 0 therefore always takes opcode 1.
- R7: When `bit_mode`=1, opcode 1 is taken when `src_val[cond_imm]` is 1, and opcode 2 is taken when that bit is 0.
- R8: Opcode 3 (jump) is always taken with a relative target.
- R9: Opcode 4 (call) is taken with a relative target and pushes P+2. Opcode 5 (return) goes to the most recently pushed address. Entries come back in last-in, first-out order, up to 4 levels.
- R10: A call made while 4 entries are held sets `seq_err`, still jumps, and stores nothing. A return made with an empty stack sets `seq_err` and continues at P+2.
- R11: A control opcode that executes in a delay slot sets `seq_err` and is ignored: `pc` still goes to the pending target.
- R12: `seq_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction at `pc` executes this cycle |
| op | input | 3 | 0 none, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump, 4 call, 5 return |
| bit_mode | input | 1 | 1: bit-test condition, 0: immediate compare |
| cond_imm | input | 5 | Immediate value or bit index |
| src_val | input | 32 | Source register value |
| rel_offset | input | 16 | Signed offset relative to the branch address |
| pc | output | 16 | Current program counter |
| seq_err | output | 1 | Sticky sequencing error |

## Verification
The hardest situations to reach from the ports are a fifth nested call and a return on an empty stack. Each needs a long, exact run of calls, delay slots and returns. A directed run builds four levels of calls, overflows the stack once, unwinds it completely, and then underflows it. Random stimulus keeps control opcodes out of delay slots most of the time, so nesting can build up. It resets periodically so the sticky flag is observed clearing and then setting again.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_BREQ = 3'd1,
        OP_BRNE = 3'd2,
        OP_JUMP = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5
    } ctrl_op_e;

    typedef enum logic {
        S_RUN  = 1'b0,
        S_SLOT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond #(
    parameter int DW = 32,
    parameter int IMW = 5
) (
    input  logic           bit_mode,
    input  logic [IMW-1:0] cond_imm,
    input  logic [DW-1:0]  src_val,
    output logic           cond_hit
);
    logic [DW-1:0] shifted;

    always_comb begin
        shifted = src_val >> cond_imm;
        if (bit_mode)
            cond_hit = shifted[0];
        else
            cond_hit = (src_val == DW'(cond_imm));
    end
endmodule

// File: rtl/pcseq_ras.sv
module pcseq_ras #(
    parameter int AW = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr,
    output logic          full,
    output logic          empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] slot_q [DEPTH];
    logic [CW-1:0] count_q;

    assign full     = (count_q == CW'(DEPTH));
    assign empty    = (count_q == '0);
    assign top_addr = slot_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (push && !full)
            count_q <= count_q + 1'b1;
        else if (pop && !empty)
            count_q <= count_q - 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (push && !full)
                slot_q[i] <= (i == 0) ? push_addr : slot_q[(i == 0) ? 0 : i - 1];
            else if (pop && !empty)
                slot_q[i] <= (i == DEPTH - 1) ? '0 : slot_q[(i == DEPTH - 1) ? i : i + 1];
        end
    end

    AST_RAS_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> !empty); // R9
    AST_RAS_POP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> !full); // R9
endmodule

// File: rtl/pc_branch_seq.sv
module pc_branch_seq
    import pcseq_pkg::*;
#(
    parameter int PCW = 16,
    parameter int DW = 32,
    parameter int RAS_DEPTH = 4,
    parameter logic [PCW-1:0] RESET_PC = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           instr_valid,
    input  logic [2:0]     op,
    input  logic           bit_mode,
    input  logic [4:0]     cond_imm,
    input  logic [DW-1:0]  src_val,
    input  logic [15:0]    rel_offset,
    output logic [PCW-1:0] pc,
    output logic           seq_err
);
    seq_state_e     state_q, state_d;
    logic [PCW-1:0] pc_q, pc_d, pend_q, pend_d;
    logic           err_q, err_set;
    logic           is_ctrl, cond_hit, taken;
    logic           push, pop, ras_full, ras_empty;
    logic [PCW-1:0] ras_top, rel_tgt, fall_tgt, tgt;
    ctrl_op_e       op_e;

    pcseq_cond #(.DW(DW), .IMW(5)) u_cond (
        .bit_mode (bit_mode),
        .cond_imm (cond_imm),
        .src_val  (src_val),
        .cond_hit (cond_hit)
    );

    pcseq_ras #(.AW(PCW), .DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_addr (fall_tgt),
        .top_addr  (ras_top),
        .full      (ras_full),
        .empty     (ras_empty)
    );

    // Target resolution
    always_comb begin
        op_e     = ctrl_op_e'(op);
        is_ctrl  = (op >= 3'd1) && (op <= 3'd5);
        rel_tgt  = pc_q + PCW'($signed(rel_offset));
        fall_tgt = pc_q + PCW'(2);
        unique case (op_e)
            OP_BREQ: taken = cond_hit;
            OP_BRNE: taken = !cond_hit;
            OP_JUMP, OP_CALL: taken = 1'b1;
            OP_RET:  taken = !ras_empty;
            default: taken = 1'b0;
        endcase
        if (op_e == OP_RET)
            tgt = ras_empty ? fall_tgt : ras_top;
        else
            tgt = taken ? rel_tgt : fall_tgt;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_RUN;
            pc_q    <= RESET_PC;
            pend_q  <= RESET_PC;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            pend_q  <= pend_d;
            err_q   <= err_q | err_set;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        pend_d  = pend_q;
        push    = 1'b0;
        pop     = 1'b0;
        err_set = 1'b0;
        unique case (state_q)
            S_RUN: begin
                if (instr_valid) begin
                    pc_d = pc_q + PCW'(1);
                    if (is_ctrl) begin
                        state_d = S_SLOT;
                        pend_d  = tgt;
                        push    = (op_e == OP_CALL) && !ras_full;
                        pop     = (op_e == OP_RET) && !ras_empty;
                        err_set = ((op_e == OP_CALL) && ras_full) ||
                                  ((op_e == OP_RET) && ras_empty);
                    end
                end
            end
            S_SLOT: begin
                if (instr_valid) begin
                    pc_d    = pend_q;
                    state_d = S_RUN;
                    err_set = is_ctrl;
                end
            end
            default: state_d = S_RUN;
        endcase
    end

    assign pc      = pc_q;
    assign seq_err = err_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(pc)); // R2
    AST_SLOT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && instr_valid && is_ctrl) |=> (pc == $past(pc) + PCW'(1))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && instr_valid && op_e == OP_CALL && ras_full) |=> seq_err); // R10
    AST_SLOT_CTRL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SLOT && instr_valid && is_ctrl) |=> seq_err); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err); // R12
endmodule

// File: tb/pc_branch_seq_bench.sv
`timescale 1ns/1ps
module pc_branch_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        bit_mode = 1'b0;
    logic [4:0]  cond_imm = 5'd0;
    logic [31:0] src_val = 32'd0;
    logic [15:0] rel_offset = 16'd0;
    logic [15:0] pc;
    logic        seq_err;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic [15:0] m_pc, m_pend;
    logic        m_slot, m_err;
    logic [15:0] m_stk [4];
    int          m_cnt;
    string       m_tag, p_tag;

    always #4 clk = ~clk;

    pc_branch_seq u_pc_branch_seq (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op(op),
        .bit_mode(bit_mode), .cond_imm(cond_imm), .src_val(src_val),
        .rel_offset(rel_offset), .pc(pc), .seq_err(seq_err)
    );

    function automatic logic cond_taken(input logic [2:0] o, input logic b,
                                        input logic [4:0] im, input logic [31:0] s);
        logic hit;
        hit = b ? s[im] : (s == {27'd0, im});
        return (o == 3'd1) ? hit : !hit;
    endfunction

    task automatic check_now();
        checks++;
        if (pc !== m_pc) begin
            errors++;
            $display("FAIL %s pc: actual=%h expected=%h", m_tag, pc, m_pc);
        end
        checks++;
        if (seq_err !== m_err) begin
            errors++;
            $display("FAIL %s R12 seq_err: actual=%b expected=%b", m_tag, seq_err, m_err);
        end
    endtask

    task automatic model_reset();
        m_pc = 16'd0; m_pend = 16'd0; m_slot = 1'b0; m_err = 1'b0;
        m_cnt = 0; m_tag = "R1 reset"; p_tag = "";
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; instr_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic step(input logic v, input logic [2:0] o, input logic b,
                        input logic [4:0] im, input logic [31:0] s, input logic [15:0] off);
        logic [15:0] tg;
        logic        ctrl;
        @(negedge clk);
        check_now();
        instr_valid = v; op = o; bit_mode = b; cond_imm = im; src_val = s; rel_offset = off;
        ctrl = (o >= 3'd1) && (o <= 3'd5);
        if (!v) begin
            m_tag = "R2 hold";
        end else if (!m_slot) begin
            if (ctrl) begin
                case (o)
                    3'd1, 3'd2: begin
                        if (cond_taken(o, b, im, s)) begin
                            tg = m_pc + off; p_tag = b ? "R7 R4 taken" : "R6 R4 taken";
                        end else begin
                            tg = m_pc + 16'd2; p_tag = b ? "R7 R5 fallthrough" : "R6 R5 fallthrough";
                        end
                    end
                    3'd3: begin tg = m_pc + off; p_tag = "R8 jump"; end
                    3'd4: begin
                        tg = m_pc + off;
                        if (m_cnt == 4) begin m_err = 1'b1; p_tag = "R10 overflow"; end
                        else begin m_stk[m_cnt] = m_pc + 16'd2; m_cnt++; p_tag = "R9 call"; end
                    end
                    default: begin
                        if (m_cnt == 0) begin m_err = 1'b1; tg = m_pc + 16'd2; p_tag = "R10 underflow"; end
                        else begin m_cnt--; tg = m_stk[m_cnt]; p_tag = "R9 return"; end
                    end
                endcase
                m_pend = tg; m_slot = 1'b1; m_pc = m_pc + 16'd1; m_tag = "R3 slot";
            end else begin
                m_pc = m_pc + 16'd1; m_tag = "R2 advance";
            end
        end else begin
            if (ctrl) begin m_err = 1'b1; m_tag = "R11 ctrl in slot"; end
            else m_tag = p_tag;
            m_pc = m_pend; m_slot = 1'b0;
        end
    endtask

    task automatic nop(); step(1'b1, 3'd0, 1'b0, 5'd0, 32'd0, 16'd0); endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned r;
        r = $urandom(32'h5eed_1234);
        do_reset();
        // R1 reset, R2 advance and hold
        nop(); nop();
        step(1'b0, 3'd1, 1'b0, 5'd0, 32'd0, 16'd50);
        // R6 equal immediate taken, forward offset
        step(1'b1, 3'd1, 1'b0, 5'd5, 32'd5, 16'd10); nop();
        // R6 not-equal, equal values -> R5 fallthrough
        step(1'b1, 3'd2, 1'b0, 5'd5, 32'd5, 16'd10); nop();
        // R6 upper bits differ -> not equal
        step(1'b1, 3'd1, 1'b0, 5'd5, 32'h1000_0005, 16'd9); nop();
        // R7 bit set taken, negative offset
        step(1'b1, 3'd1, 1'b1, 5'd7, 32'h80, 16'hfffc); nop();
        // R7 bit 31 clear, not-equal taken
        step(1'b1, 3'd2, 1'b1, 5'd31, 32'h7fff_ffff, 16'd40); nop();
        // R6 zero source unconditional
        step(1'b1, 3'd1, 1'b0, 5'd0, 32'd0, 16'd100); nop();
        // R8 jump, wrap below zero
        step(1'b1, 3'd3, 1'b0, 5'd0, 32'd0, 16'h8000); nop();
        // R9 four nested calls, R10 fifth overflows
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 3'd4, 1'b0, 5'd0, 32'd0, 16'd20 + 16'(i)); nop(); nop();
        end
        // R9 returns in LIFO order, then R10 underflow
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 3'd5, 1'b0, 5'd0, 32'd0, 16'd0); nop();
        end
        // R12 still set after plain instructions
        nop(); nop();
        // R11 control op in slot
        do_reset();
        step(1'b1, 3'd3, 1'b0, 5'd0, 32'd0, 16'd30);
        step(1'b1, 3'd3, 1'b0, 5'd0, 32'd0, 16'd200);
        nop(); nop();
        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic v, b;
            logic [2:0] o;
            logic [4:0] im;
            logic [31:0] s;
            if (n % 600 == 599) do_reset();
            v  = ($urandom % 10) != 0;
            o  = (($urandom % 10) < 4) ? 3'd0 : 3'($urandom % 8);
            if (m_slot && ($urandom % 8) != 0) o = 3'd0;
            b  = 1'($urandom);
            im = 5'($urandom);
            s  = (($urandom % 3) == 0) ? ({27'd0, im} ^ (32'd1 << ($urandom % 32)) & {32{b}})
                                        : 32'($urandom);
            if (($urandom % 4) == 0 && !b) s = {27'd0, im};
            step(v, o, b, im, s, 16'($urandom));
        end
        @(negedge clk);
        check_now();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule